// File: doc/BRIEF.md
# Debug Transfer Address Sequencer

This block turns each debug data access into one or more bus transfers and keeps the running transfer address. A debug access names a register by its word index: the address register, the main data register, or one of four banked data registers. Writing the address register loads the running address. An access to the main data register issues bus transfers at the running address and, depending on the increment mode, moves the address on. Each move wraps inside a 1 KB window, and the address moves only on an error-free completion. In packed mode, one 32-bit debug access becomes two halfword or four byte bus transfers. The block merges their read data into one word.

A banked access reaches one of four word locations in the 16-byte block that holds the running address. It never moves the address. Bus handshake timing and access authorisation belong to the surrounding logic. The bus side only reports completion and error for each transfer.

Top module: `addr_seq`

## Requirements
- R1: After reset the running address (`cur_addr`) is 0x00000000, and `bus_req` and `acc_done` are low.
- R2: A request with index 1 loads `req_wdata` into the running address. It raises `acc_done` in the next cycle and starts no bus transfer.
- R3: A request with index 3 starts a transfer at the running address. With increment mode 1 (single) or 2 (packed), the address grows by 1, 2 or 4 bytes for size code 0, 1 or 2 after each error-free completion. With mode 0 the address stays unchanged.
- R4: Each increment changes only address bits [9:0], modulo 1024. Bits [31:10] stay fixed.
- R5: A completion with `bus_err` high leaves the running address unchanged. It ends the access with `acc_done` and `acc_err` high in the next cycle.
- R6: In packed mode, size 0 issues four bus transfers and size 1 issues two, each at the incremented address. Size 2 issues one transfer. `bus_size` equals the size code for each transfer.
- R7: Read data is built from the byte lanes that each transfer's address selects: lane addr[1:0] for a byte, lanes 2·addr[1] and 2·addr[1]+1 for a halfword, all lanes for a word. Lanes that no transfer wrote read as zero. The result appears on `acc_rdata` together with `acc_done`.
- R8: An error on any packed sub-transfer cancels the remaining sub-transfers. The running address stays at the failing location.
- R9: A request with index 4 to 7 issues exactly one word transfer (`bus_size` = 2) at {cur_addr[31:4], index[1:0], 2'b00}. It leaves the running address unchanged, whatever the mode and size.
- R10: A request with index 3 and increment mode 3 or a size code above 2 issues no transfer. It raises `acc_done` with `acc_err` low and leaves the running address unchanged.
- R11: Requests with index 0 or 2 are ignored: no transfer, no `acc_done`, no address change.
- R12: `bus_req` stays high and `bus_addr` stays stable until the transfer completes. `acc_done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Debug access request, sampled while idle |
| req_idx | input | 3 | Register word index (1 address, 3 data, 4-7 banked) |
| req_wdata | input | 32 | New address value for index 1 |
| cfg_size | input | 3 | Access size code (0 byte, 1 halfword, 2 word) |
| cfg_inc | input | 2 | Increment mode (0 off, 1 single, 2 packed, 3 reserved) |
| bus_req | output | 1 | Bus transfer pending |
| bus_addr | output | 32 | Bus transfer address |
| bus_size | output | 3 | Bus transfer size code |
| bus_done | input | 1 | Current transfer completes this cycle |
| bus_err | input | 1 | Completing transfer returned an error |
| bus_rdata | input | 32 | Read data of the completing transfer |
| acc_done | output | 1 | Debug access finished |
| acc_err | output | 1 | Debug access ended on a bus error |
| acc_rdata | output | 32 | Assembled read data |
| cur_addr | output | 32 | Running transfer address |

## Verification
The bench starts word and byte sequences next to the 1 KB limit, including a packed halfword run that crosses it. A design that carried into bit 10 would leave the window there. Errors are injected on a single transfer and on the second byte of a packed access. A design that still incremented, or finished the packed run, would show a wrong address or the wrong transfer count. All four banked indices run with a byte size and increment mode set, so leaked mode bits would show up as a non-word size or a moved address. The bus model returns data derived from each address, so a design that placed packed data in the wrong lanes returns a different word.

// File: rtl/addr_seq.sv
module addr_seq #(
  parameter int AW     = 32,
  parameter int WRAP_W = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_idx,
  input  logic [AW-1:0] req_wdata,
  input  logic [2:0]    cfg_size,
  input  logic [1:0]    cfg_inc,
  output logic          bus_req,
  output logic [AW-1:0] bus_addr,
  output logic [2:0]    bus_size,
  input  logic          bus_done,
  input  logic          bus_err,
  input  logic [31:0]   bus_rdata,
  output logic          acc_done,
  output logic          acc_err,
  output logic [31:0]   acc_rdata,
  output logic [AW-1:0] cur_addr
);
  localparam logic [2:0] IDX_ADDR = 3'd1;
  localparam logic [2:0] IDX_DATA = 3'd3;

  logic              busy, banked;
  logic [1:0]        bank, inc_q;
  logic [2:0]        size_q, left;
  logic [AW-1:0]     tar;
  logic [31:0]       assem, lane_mask;
  logic [WRAP_W-1:0] step;
  logic [AW-1:0]     tar_inc;
  logic              reserved;

  assign reserved = (cfg_inc == 2'b11) || (cfg_size > 3'd2);
  assign step     = WRAP_W'(1) << size_q[1:0];
  assign tar_inc  = {tar[AW-1:WRAP_W], tar[WRAP_W-1:0] + step};

  assign bus_req   = busy;
  assign bus_addr  = banked ? {tar[AW-1:4], bank, 2'b00} : tar;
  assign bus_size  = size_q;
  assign acc_rdata = assem;
  assign cur_addr  = tar;

  always_comb begin
    case (size_q)
      3'd0:    lane_mask = 32'h0000_00FF << {bus_addr[1:0], 3'b000};
      3'd1:    lane_mask = 32'h0000_FFFF << {bus_addr[1], 4'b0000};
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      banked   <= 1'b0;
      bank     <= 2'd0;
      inc_q    <= 2'd0;
      size_q   <= 3'd2;
      left     <= 3'd0;
      tar      <= '0;
      assem    <= '0;
      acc_done <= 1'b0;
      acc_err  <= 1'b0;
    end else begin
      acc_done <= 1'b0;
      acc_err  <= 1'b0;
      if (!busy && req_valid) begin
        if (req_idx == IDX_ADDR) begin
          tar      <= req_wdata;
          acc_done <= 1'b1;
        end else if (req_idx == IDX_DATA) begin
          assem <= '0;
          if (reserved) begin
            acc_done <= 1'b1;
          end else begin
            busy   <= 1'b1;
            banked <= 1'b0;
            size_q <= cfg_size;
            inc_q  <= cfg_inc;
            if (cfg_inc == 2'b10 && cfg_size == 3'd0)      left <= 3'd4;
            else if (cfg_inc == 2'b10 && cfg_size == 3'd1) left <= 3'd2;
            else                                           left <= 3'd1;
          end
        end else if (req_idx[2]) begin
          assem  <= '0;
          busy   <= 1'b1;
          banked <= 1'b1;
          bank   <= req_idx[1:0];
          size_q <= 3'd2;
          inc_q  <= 2'b00;
          left   <= 3'd1;
        end
      end else if (busy && bus_done) begin
        if (bus_err) begin
          busy     <= 1'b0;
          acc_done <= 1'b1;
          acc_err  <= 1'b1;
        end else begin
          assem <= (assem & ~lane_mask) | (bus_rdata & lane_mask);
          if (!banked && inc_q != 2'b00) tar <= tar_inc;
          left <= left - 3'd1;
          if (left == 3'd1) begin
            busy     <= 1'b0;
            acc_done <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/addr_seq_chk.sv
module addr_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [2:0]    req_idx,
  input logic [AW-1:0] req_wdata,
  input logic [2:0]    cfg_size,
  input logic [1:0]    cfg_inc,
  input logic          bus_req,
  input logic [AW-1:0] bus_addr,
  input logic [2:0]    bus_size,
  input logic          bus_done,
  input logic          bus_err,
  input logic          acc_done,
  input logic          acc_err,
  input logic [AW-1:0] cur_addr
);
  // R2
  addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !bus_req && req_idx == 3'd1 |=> cur_addr == $past(req_wdata) && !bus_req && acc_done);

  // R5
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_done && bus_err |=> cur_addr == $past(cur_addr) && acc_done && acc_err && !bus_req);

  // R9
  bank_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !bus_req && req_idx[2] |=> bus_req && bus_size == 3'd2 && bus_addr[3:0] == {$past(req_idx[1:0]), 2'b00});

  // R10
  reserved_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !bus_req && req_idx == 3'd3 && (cfg_inc == 2'b11 || cfg_size > 3'd2)
    |=> !bus_req && acc_done && !acc_err);

  // R11
  idx_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !bus_req && (req_idx == 3'd0 || req_idx == 3'd2) |=> !bus_req && !acc_done);

  // R12
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_done |=> bus_req && $stable(bus_addr) && $stable(bus_size));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |=> !acc_done);
endmodule

bind addr_seq addr_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_idx(req_idx),
  .req_wdata(req_wdata), .cfg_size(cfg_size), .cfg_inc(cfg_inc),
  .bus_req(bus_req), .bus_addr(bus_addr), .bus_size(bus_size),
  .bus_done(bus_done), .bus_err(bus_err), .acc_done(acc_done),
  .acc_err(acc_err), .cur_addr(cur_addr)
);

// File: tb/sim_addr_seq.sv
module sim_addr_seq;
  localparam int PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_idx = '0;
  logic [31:0] req_wdata = '0;
  logic [2:0]  cfg_size = 3'd2;
  logic [1:0]  cfg_inc = 2'b00;
  logic        bus_req, bus_done = 1'b0, bus_err = 1'b0;
  logic [31:0] bus_addr, bus_rdata = '0;
  logic [2:0]  bus_size;
  logic        acc_done, acc_err;
  logic [31:0] acc_rdata, cur_addr;

  int checks = 0, fails = 0;
  int n_xfer = 0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [31:0] last_addr = '0;
  logic [2:0]  last_size = '0;
  logic        got_done, got_err;
  logic [31:0] got_rdata;

  always #(PERIOD/2) clk = ~clk;

  addr_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_idx(req_idx),
    .req_wdata(req_wdata), .cfg_size(cfg_size), .cfg_inc(cfg_inc),
    .bus_req(bus_req), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_done(bus_done), .bus_err(bus_err), .bus_rdata(bus_rdata),
    .acc_done(acc_done), .acc_err(acc_err), .acc_rdata(acc_rdata),
    .cur_addr(cur_addr)
  );

  always @(negedge clk) begin
    if (bus_req && !bus_done) begin
      bus_done  <= 1'b1;
      bus_err   <= (bus_addr == err_addr);
      bus_rdata <= {4{bus_addr[7:0]}};
      last_addr <= bus_addr;
      last_size <= bus_size;
      n_xfer    <= n_xfer + 1;
    end else begin
      bus_done <= 1'b0;
      bus_err  <= 1'b0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic [2:0] idx, input logic [31:0] wd, input int limit);
    @(negedge clk);
    n_xfer    = 0;
    req_valid = 1'b1;
    req_idx   = idx;
    req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < limit && !acc_done; k++) @(negedge clk);
    got_done  = acc_done;
    got_err   = acc_err;
    got_rdata = acc_rdata;
  endtask

  typedef struct packed {
    logic [2:0]  idx;
    logic [31:0] start;
    logic [2:0]  size;
    logic [1:0]  inc;
    logic [31:0] eaddr;
    logic [31:0] tar;
    logic [31:0] rdata;
    logic [31:0] last;
    logic [2:0]  cnt;
    logic        err;
  } vec_t;

  localparam logic [31:0] NE = 32'hFFFF_FFFF;
  localparam vec_t VEC [16] = '{
    '{3'd3, 32'h0000_14A0, 3'd2, 2'd1, NE,           32'h0000_14A4, 32'hA0A0_A0A0, 32'h0000_14A0, 3'd1, 1'b0},
    '{3'd3, 32'h0000_17FC, 3'd2, 2'd1, NE,           32'h0000_1400, 32'hFCFC_FCFC, 32'h0000_17FC, 3'd1, 1'b0},
    '{3'd3, 32'h1234_5FFF, 3'd0, 2'd1, NE,           32'h1234_5C00, 32'hFF00_0000, 32'h1234_5FFF, 3'd1, 1'b0},
    '{3'd3, 32'h0000_0105, 3'd0, 2'd0, NE,           32'h0000_0105, 32'h0000_0500, 32'h0000_0105, 3'd1, 1'b0},
    '{3'd3, 32'h0000_0100, 3'd0, 2'd2, NE,           32'h0000_0104, 32'h0302_0100, 32'h0000_0103, 3'd4, 1'b0},
    '{3'd3, 32'h0000_0200, 3'd1, 2'd2, NE,           32'h0000_0204, 32'h0202_0000, 32'h0000_0202, 3'd2, 1'b0},
    '{3'd3, 32'h0000_0300, 3'd2, 2'd2, NE,           32'h0000_0304, 32'h0000_0000, 32'h0000_0300, 3'd1, 1'b0},
    '{3'd3, 32'h0000_03FE, 3'd1, 2'd2, NE,           32'h0000_0002, 32'hFEFE_0000, 32'h0000_0000, 3'd2, 1'b0},
    '{3'd3, 32'h0000_0400, 3'd2, 2'd3, NE,           32'h0000_0400, 32'h0000_0000, 32'h0000_0000, 3'd0, 1'b0},
    '{3'd3, 32'h0000_0700, 3'd3, 2'd1, NE,           32'h0000_0700, 32'h0000_0000, 32'h0000_0000, 3'd0, 1'b0},
    '{3'd3, 32'h0000_0500, 3'd2, 2'd1, 32'h0000_0500, 32'h0000_0500, 32'h0000_0000, 32'h0000_0500, 3'd1, 1'b1},
    '{3'd3, 32'h0000_0610, 3'd0, 2'd2, 32'h0000_0611, 32'h0000_0611, 32'h0000_0010, 32'h0000_0611, 3'd2, 1'b1},
    '{3'd4, 32'h1234_567B, 3'd0, 2'd1, NE,           32'h1234_567B, 32'h7070_7070, 32'h1234_5670, 3'd1, 1'b0},
    '{3'd5, 32'h1234_567B, 3'd0, 2'd1, NE,           32'h1234_567B, 32'h7474_7474, 32'h1234_5674, 3'd1, 1'b0},
    '{3'd6, 32'h1234_567B, 3'd0, 2'd1, NE,           32'h1234_567B, 32'h7878_7878, 32'h1234_5678, 3'd1, 1'b0},
    '{3'd7, 32'h1234_567B, 3'd0, 2'd1, NE,           32'h1234_567B, 32'h7C7C_7C7C, 32'h1234_567C, 3'd1, 1'b0}
  };

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cur_addr", cur_addr, 32'h0);
    check("R1 bus_req", {31'd0, bus_req}, 32'd0);
    check("R1 acc_done", {31'd0, acc_done}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 address load
    access(3'd1, 32'hCAFE_0040, 10);
    check("R2 done", {31'd0, got_done}, 32'd1);
    check("R2 address", cur_addr, 32'hCAFE_0040);
    check("R2 no transfer", n_xfer, 0);

    // R11 ignored indices
    for (int j = 0; j < 2; j++) begin
      access(j == 0 ? 3'd0 : 3'd2, 32'h1111_1111, 8);
      check("R11 no done", {31'd0, got_done}, 32'd0);
      check("R11 no transfer", n_xfer, 0);
      check("R11 address kept", cur_addr, 32'hCAFE_0040);
    end

    foreach (VEC[i]) begin
      err_addr = NE;
      access(3'd1, VEC[i].start, 10);
      cfg_size = VEC[i].size;
      cfg_inc  = VEC[i].inc;
      err_addr = VEC[i].eaddr;
      access(VEC[i].idx, 32'h0, 40);
      // R3 R4 R5 R8 R9 R10: final address
      check($sformatf("R3/R4/R5/R8/R9 vec%0d address", i), cur_addr, VEC[i].tar);
      check($sformatf("R6/R8/R10 vec%0d count", i), n_xfer, int'(VEC[i].cnt));
      check($sformatf("R5/R8 vec%0d err", i), {31'd0, got_err}, {31'd0, VEC[i].err});
      check($sformatf("R12 vec%0d done", i), {31'd0, got_done}, 32'd1);
      if (!VEC[i].err)
        check($sformatf("R7 vec%0d rdata", i), got_rdata, VEC[i].rdata);
      else if (VEC[i].cnt > 1)
        check($sformatf("R8 vec%0d partial rdata", i), got_rdata, VEC[i].rdata);
      if (VEC[i].cnt != 0) begin
        check($sformatf("R6/R9 vec%0d last address", i), last_addr, VEC[i].last);
        check($sformatf("R6/R9 vec%0d size", i), {29'd0, last_size},
              {29'd0, (VEC[i].idx[2] ? 3'd2 : VEC[i].size)});
      end
      @(negedge clk);
      check($sformatf("R12 vec%0d single pulse", i), {31'd0, acc_done}, 32'd0);
    end

    // R4 repeated increments around the window edge
    err_addr = NE;
    cfg_size = 3'd2;
    cfg_inc  = 2'b01;
    access(3'd1, 32'hABCD_17F8, 10);
    for (int j = 0; j < 3; j++) access(3'd3, 32'h0, 20);
    check("R4 three words across wrap", cur_addr, 32'hABCD_1404);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule